// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block detects interrupt events on one GPIO bank of four ports with eight pins each. It takes the synchronized pin levels, a 24-bit trigger-type word for each port, a per-pin enable, and per-pin write-one-to-clear pulses. For each pin it keeps a sticky status bit. It drives a single bank interrupt line that is high while any pin has both status and enable set.

Each pin has its own trigger mode: rising edge, falling edge, both edges, level high or level low. Edges are found by comparing each pin with the level it had on the previous cycle. Status bits are tracked whether or not the pin is enabled, so the enable acts only as an output mask. The register bank that decodes software accesses sits outside this block. It feeds the trigger words, enables and clear pulses directly.

Top module: `gpio_irq_detect`

## Requirements
- R1: While reset is asserted, and right after it, every status bit and the bank interrupt are 0.
- R2: An edge is never reported on the first clock edge after reset is released. A pin that is already high at release does not count as rising.
- R3: Port p holds its trigger word in trig_cfg[p*24 +: 24]. For pin b of that port (pin index p*8+b), bit b is polarity, bit b+8 is edge mode and bit b+16 is both-edges. A value with polarity and edge mode set (rising) sets the status bit on the clock edge after the pin goes from 0 to 1. A 1-to-0 change does not set it.
- R4: With only edge mode set (falling), status is set on a 1-to-0 change and not on a 0-to-1 change.
- R5: With edge mode and both-edges set, status is set on either change.
- R6: With only polarity set (level high), status is set on every clock edge where the pin is 1. A clear given while the pin stays 1 leaves the status bit set.
- R7: With all three bits 0 (level low), status is set on every clock edge where the pin is 0.
- R8: A status bit stays set until a clear pulse is given for that pin. A clear affects only the pins whose clear bit is 1.
- R9: If a qualifying event and a clear for the same pin arrive on the same cycle, the status bit ends up set.
- R10: Status bits are updated whatever their enable bit holds.
- R11: bank_irq is the OR over all 32 pins of status AND enable. It follows changes of the enable inputs without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_lvl | input | 32 | Synchronized pin levels, pin index p*8+b |
| trig_cfg | input | 96 | Trigger-type words, 24 bits per port |
| irq_en | input | 32 | Per-pin interrupt enable |
| sts_clr | input | 32 | Per-pin write-one-to-clear pulse |
| sts | output | 32 | Sticky interrupt status |
| bank_irq | output | 1 | Bank interrupt, OR of enabled status |

## Verification
The hardest case to reach is a clear that lands on the same cycle as a new edge on the same pin. The bench brings it about by driving the pin's rising transition and its clear pulse in the same half-cycle, so both are seen at one clock edge. A pin already high at reset release is a second such case. The bench holds the pin high through reset under rising mode, then confirms that no status appears at release. Level-mode re-assertion is reached by clearing a pin whose level still matches its polarity.

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int PORTS = 4,
  parameter int PINS  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PORTS*PINS-1:0]   pin_lvl,
  input  logic [PORTS*PINS*3-1:0] trig_cfg,
  input  logic [PORTS*PINS-1:0]   irq_en,
  input  logic [PORTS*PINS-1:0]   sts_clr,
  output logic [PORTS*PINS-1:0]   sts,
  output logic                    bank_irq
);
  localparam int N     = PORTS * PINS;
  localparam int WORDW = PINS * 3;

  logic [N-1:0] prev, pol_v, edg_v, both_v, rise, fall, hit;
  logic         primed;

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    for (genvar b = 0; b < PINS; b++) begin : g_pin
      localparam int I = p * PINS + b;
      assign pol_v[I]  = trig_cfg[p*WORDW + b];
      assign edg_v[I]  = trig_cfg[p*WORDW + PINS + b];
      assign both_v[I] = trig_cfg[p*WORDW + 2*PINS + b];
    end
  end

  assign rise = {N{primed}} & pin_lvl & ~prev;
  assign fall = {N{primed}} & ~pin_lvl & prev;
  assign hit  = (edg_v & both_v & (rise | fall))
              | (edg_v & ~both_v & ((pol_v & rise) | (~pol_v & fall)))
              | (~edg_v & ~(pin_lvl ^ pol_v));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev   <= '0;
      primed <= 1'b0;
      sts    <= '0;
    end else begin
      prev   <= pin_lvl;
      primed <= 1'b1;
      sts    <= hit | (sts & ~sts_clr);
    end
  end

  assign bank_irq = |(sts & irq_en);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(sts) & ~$past(sts_clr)) & ~sts) == '0));
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts & $past(sts_clr & ~hit)) == '0));
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(hit) & ~sts) == '0));
  a_r2_no_first_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |=> ((sts & $past(edg_v) & ~$past(sts)) == '0));
  a_r11_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bank_irq) |-> ((sts & irq_en) != $past(sts & irq_en)));
endmodule

// File: tb/sim_gpio_irq_detect.sv
module sim_gpio_irq_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_lvl = '0;
  logic [95:0] cfg = '0;
  logic [31:0] irq_en = '0;
  logic [31:0] sts_clr = '0;
  logic [31:0] sts;
  logic        bank_irq;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  gpio_irq_detect u0 (.clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .trig_cfg(cfg),
    .irq_en(irq_en), .sts_clr(sts_clr), .sts(sts), .bank_irq(bank_irq));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // mode = {both, edge, pol}
  task automatic set_mode(int p, int b, logic [2:0] m);
    cfg[p*24 + b]      = m[0];
    cfg[p*24 + 8 + b]  = m[1];
    cfg[p*24 + 16 + b] = m[2];
  endtask

  task automatic clear(logic [31:0] m);
    sts_clr = m; tick(); sts_clr = '0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 32; i++) set_mode(i / 8, i % 8, 3'b011);
    pin_lvl = 32'h1;
    rst_n = 1'b0;
    repeat (3) tick();
    chk("R1 sts in reset", sts, '0);
    chk("R1 irq in reset", {31'b0, bank_irq}, '0);
    rst_n = 1'b1;
    tick();
    chk("R2 no edge at release", sts, '0);
    tick();
    chk("R2 still none", sts, '0);
    pin_lvl = '0; tick();
  endtask

  task automatic t_rise();
    pin_lvl[3] = 1'b1; tick();
    chk("R3 rise sets", sts, 32'h8);
    chk("R10 irq masked", {31'b0, bank_irq}, '0);
    irq_en = 32'h8; #1;
    chk("R11 irq follows enable", {31'b0, bank_irq}, 1);
    tick();
    chk("R8 sticky", sts, 32'h8);
    clear(32'h8);
    chk("R8 cleared", sts, '0);
    chk("R11 irq drops", {31'b0, bank_irq}, '0);
    pin_lvl[3] = 1'b0; tick();
    chk("R3 fall ignored", sts, '0);
    irq_en = '0;
  endtask

  task automatic t_fall();
    set_mode(2, 5, 3'b010);
    pin_lvl[21] = 1'b1; tick();
    chk("R4 rise ignored", sts, '0);
    pin_lvl[21] = 1'b0; tick();
    chk("R4 fall sets", sts, 32'h0020_0000);
    clear(32'h0020_0000);
    set_mode(2, 5, 3'b011);
  endtask

  task automatic t_both();
    set_mode(1, 0, 3'b110);
    pin_lvl[8] = 1'b1; tick();
    chk("R5 rise sets", sts, 32'h100);
    clear(32'h100);
    chk("R5 cleared", sts, '0);
    pin_lvl[8] = 1'b0; tick();
    chk("R5 fall sets", sts, 32'h100);
    clear(32'h100);
    set_mode(1, 0, 3'b011);
  endtask

  task automatic t_level();
    set_mode(1, 4, 3'b001);
    tick();
    chk("R6 low pin no set", sts, '0);
    pin_lvl[12] = 1'b1; tick();
    chk("R6 high sets", sts, 32'h1000);
    clear(32'h1000);
    chk("R6 reasserts after clear", sts, 32'h1000);
    pin_lvl[12] = 1'b0; clear(32'h1000);
    chk("R6 drops after clear", sts, '0);
    set_mode(1, 4, 3'b011);
    set_mode(2, 1, 3'b000);
    tick();
    chk("R7 low level sets", sts, 32'h0002_0000);
    pin_lvl[17] = 1'b1; clear(32'h0002_0000);
    chk("R7 high clears", sts, '0);
    set_mode(2, 1, 3'b011);
    pin_lvl[17] = 1'b0; tick();
  endtask

  task automatic t_collide();
    pin_lvl[30] = 1'b1; sts_clr = 32'h4000_0000; tick(); sts_clr = '0;
    chk("R9 set wins over clear", sts, 32'h4000_0000);
    clear(32'h4000_0000);
    chk("R9 later clear works", sts, '0);
    pin_lvl[30] = 1'b0; tick();
  endtask

  task automatic t_or();
    pin_lvl[0] = 1'b1; pin_lvl[31] = 1'b1; tick();
    chk("R10 both set", sts, 32'h8000_0001);
    irq_en = 32'h8000_0000; #1;
    chk("R11 port3 irq", {31'b0, bank_irq}, 1);
    clear(32'h8000_0000);
    chk("R8 only cleared bit", sts, 32'h1);
    chk("R11 masked bit no irq", {31'b0, bank_irq}, '0);
    irq_en = 32'h1; #1;
    chk("R11 port0 irq", {31'b0, bank_irq}, 1);
    clear(32'hFFFF_FFFF);
    irq_en = '0; pin_lvl = '0; tick();
  endtask

  initial begin
    tick();
    t_reset();
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_collide();
    t_or();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule